// File: doc/BRIEF.md
# Codec Register Configuration Sequencer

This block keeps the control registers of an AC97 audio codec programmed while the system runs. It holds a short fixed list of register writes (master volume, headphone volume, PCM output volume and record-source select) and presents one of them at a time as a command address, command data and a valid flag. The serial frame engine places that command in the command slots of its outgoing frame. When the engine has taken the command it raises a one-cycle ready pulse, and the sequencer moves on to the next list entry. After the last entry it returns to the first, so the codec is rewritten continuously, one register per frame.

The write data is not fixed. A 5-bit attenuation level and a 3-bit record-source code come from user inputs, and they are folded into the data word each time a new entry is loaded. A change of the switches therefore reaches the codec within one pass of the list, with no reset. After reset the sequencer stays silent until the codec reports that it is ready. It then issues the first entry.

Top module: `codec_cfg_seq`

## Requirements
- R1: While reset is asserted and on the first cycle after it is released, `cmd_vld_o` is 0 and `cmd_addr_o` and `cmd_data_o` are all zeros.
- R2: While `codec_ready_i` has never been seen high since reset, `cmd_vld_o` stays 0 even when ready pulses arrive. On the clock edge that samples `codec_ready_i` high, the first list entry (address 0x02) is loaded with `cmd_vld_o` = 1.
- R3: Each ready pulse taken while valid loads the next entry on the following edge. The address order is 0x02, 0x04, 0x18, 0x1A, and after 0x1A the list returns to 0x02.
- R4: When no ready pulse arrives, `cmd_addr_o`, `cmd_data_o` and `cmd_vld_o` hold their values, even if the user inputs change.
- R5: For the three volume entries (0x02, 0x04, 0x18), the data word is the volume code in bits 12:8 and again in bits 4:0. All other bits are 0, so the mute bit 15 is cleared.
- R6: For the record-select entry (0x1A), the data word is the source code in bits 10:8 and again in bits 2:0. All other bits are 0.
- R7: `cmd_addr_o` bit 7 is 0, which marks a write, whenever `cmd_vld_o` is 1.
- R8: The volume and source codes placed in a newly loaded entry are the values of `vol_i` and `src_sel_i` in the cycle of the ready pulse (or of the codec-ready edge for the first entry).
- R9: Once `cmd_vld_o` is 1, it stays 1 until the next reset.
- R10: Once the sequencer is running, `codec_ready_i` has no effect: a later low level neither stops nor restarts the list.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| codec_ready_i | input | 1 | Codec reports that it accepts register writes |
| frame_rdy_i | input | 1 | One-cycle pulse from the frame engine: current command taken |
| src_sel_i | input | 3 | Record-source code |
| vol_i | input | 5 | Attenuation level applied to left and right |
| cmd_addr_o | output | 8 | Command address; bit 7 = 0 for a write, bits 6:0 the register index |
| cmd_data_o | output | 16 | Command write data |
| cmd_vld_o | output | 1 | Command valid, held until the next ready pulse |

## Verification
The bench builds the block with its defaults: four list entries, a 5-bit volume and a 3-bit source code. At these widths every volume code and every source code can be swept. The bench runs 256 ready pulses over all 32 × 8 input combinations, which carries the list around its wrap point 64 times with a different data value on each lap. Between pulses it changes the inputs and lets several idle cycles pass, to show that the held command does not move. It also sends pulses before the codec is ready and lowers the ready input after start-up, to cover the start and ignore cases.

// File: rtl/codec_cfg_pkg.sv
package codec_cfg_pkg;

  localparam int unsigned CMD_ADDR_W = 8;
  localparam int unsigned CMD_DATA_W = 16;
  localparam int unsigned LIST_LEN   = 4;
  localparam int unsigned HI_LSB     = 8;

  typedef enum logic [0:0] {
    SEQ_IDLE = 1'b0,
    SEQ_RUN  = 1'b1
  } seq_state_t;

  // Register index written by list entry k (order is behaviour).
  function automatic logic [CMD_ADDR_W-2:0] entry_reg(input int unsigned k);
    case (k)
      0:       entry_reg = 7'h02;
      1:       entry_reg = 7'h04;
      2:       entry_reg = 7'h18;
      default: entry_reg = 7'h1A;
    endcase
  endfunction

  // Entry k carries the record-source code instead of a volume.
  function automatic logic entry_is_src(input int unsigned k);
    entry_is_src = (k == 3);
  endfunction

endpackage

// File: rtl/cfg_index_ctr.sv
module cfg_index_ctr #(
  parameter int unsigned N_ENTRIES = 4,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  output logic [IDX_W-1:0] idx_q,
  output logic [IDX_W-1:0] idx_nxt
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N_ENTRIES - 1);

  logic [IDX_W-1:0] idx_r;

  always_comb begin
    if (idx_r == LAST) idx_nxt = '0;
    else               idx_nxt = idx_r + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_r <= '0;
    else if (adv_en) idx_r <= idx_nxt;
  end

  assign idx_q = idx_r;

endmodule

// File: rtl/cfg_entry_map.sv
module cfg_entry_map
  import codec_cfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = LIST_LEN,
  parameter int unsigned VOL_W     = 5,
  parameter int unsigned SRC_W     = 3,
  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic [IDX_W-1:0]      idx,
  input  logic [VOL_W-1:0]      vol,
  input  logic [SRC_W-1:0]      src,
  output logic [CMD_ADDR_W-1:0] addr,
  output logic [CMD_DATA_W-1:0] data
);

  logic [CMD_DATA_W-1:0] vol_word;
  logic [CMD_DATA_W-1:0] src_word;

  always_comb begin
    vol_word = '0;
    vol_word[HI_LSB +: VOL_W] = vol;
    vol_word[0 +: VOL_W]      = vol;
    src_word = '0;
    src_word[HI_LSB +: SRC_W] = src;
    src_word[0 +: SRC_W]      = src;
  end

  logic [CMD_ADDR_W-1:0] addr_tab [N_ENTRIES];
  logic [CMD_DATA_W-1:0] data_tab [N_ENTRIES];

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_entry
    assign addr_tab[g] = {1'b0, entry_reg(g)};
    if (entry_is_src(g)) begin : g_src
      assign data_tab[g] = src_word;
    end else begin : g_vol
      assign data_tab[g] = vol_word;
    end
  end

  assign addr = addr_tab[idx];
  assign data = data_tab[idx];

endmodule

// File: rtl/cfg_ctrl_fsm.sv
module cfg_ctrl_fsm
  import codec_cfg_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic codec_ready,
  input  logic frame_rdy,
  output logic load_en,
  output logic adv_en,
  output logic use_next,
  output logic running
);

  seq_state_t state_q, state_d;

  always_comb begin
    state_d  = state_q;
    load_en  = 1'b0;
    adv_en   = 1'b0;
    use_next = 1'b0;
    case (state_q)
      SEQ_IDLE: begin
        if (codec_ready) begin
          load_en = 1'b1;
          state_d = SEQ_RUN;
        end
      end
      SEQ_RUN: begin
        if (frame_rdy) begin
          load_en  = 1'b1;
          adv_en   = 1'b1;
          use_next = 1'b1;
        end
      end
      default: state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= SEQ_IDLE;
    else        state_q <= state_d;
  end

  assign running = (state_q == SEQ_RUN);

endmodule

// File: rtl/codec_cfg_seq.sv
module codec_cfg_seq
  import codec_cfg_pkg::*;
#(
  parameter int unsigned N_ENTRIES = LIST_LEN,
  parameter int unsigned VOL_W     = 5,
  parameter int unsigned SRC_W     = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  codec_ready_i,
  input  logic                  frame_rdy_i,
  input  logic [SRC_W-1:0]      src_sel_i,
  input  logic [VOL_W-1:0]      vol_i,
  output logic [CMD_ADDR_W-1:0] cmd_addr_o,
  output logic [CMD_DATA_W-1:0] cmd_data_o,
  output logic                  cmd_vld_o
);

  localparam int unsigned IDX_W = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1;

  logic             load_en, adv_en, use_next, running;
  logic [IDX_W-1:0] idx_q, idx_nxt, idx_sel;
  logic [CMD_ADDR_W-1:0] map_addr;
  logic [CMD_DATA_W-1:0] map_data;
  logic [CMD_ADDR_W-1:0] addr_q;
  logic [CMD_DATA_W-1:0] data_q;
  logic                  vld_q;

  cfg_ctrl_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .codec_ready (codec_ready_i),
    .frame_rdy   (frame_rdy_i),
    .load_en     (load_en),
    .adv_en      (adv_en),
    .use_next    (use_next),
    .running     (running)
  );

  cfg_index_ctr #(.N_ENTRIES(N_ENTRIES)) u_idx (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv_en  (adv_en),
    .idx_q   (idx_q),
    .idx_nxt (idx_nxt)
  );

  assign idx_sel = use_next ? idx_nxt : idx_q;

  cfg_entry_map #(
    .N_ENTRIES (N_ENTRIES),
    .VOL_W     (VOL_W),
    .SRC_W     (SRC_W)
  ) u_map (
    .idx  (idx_sel),
    .vol  (vol_i),
    .src  (src_sel_i),
    .addr (map_addr),
    .data (map_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load_en) begin
      addr_q <= map_addr;
      data_q <= map_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= running | load_en;
  end

  assign cmd_addr_o = addr_q;
  assign cmd_data_o = data_q;
  assign cmd_vld_o  = vld_q;

endmodule

// File: rtl/codec_cfg_seq_chk.sv
module codec_cfg_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        codec_ready_i,
  input logic        frame_rdy_i,
  input logic [2:0]  src_sel_i,
  input logic [4:0]  vol_i,
  input logic [7:0]  cmd_addr_o,
  input logic [15:0] cmd_data_o,
  input logic        cmd_vld_o
);

  p_idle_until_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmd_vld_o && !codec_ready_i) |=> !cmd_vld_o);

  p_first_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmd_vld_o) |-> (cmd_addr_o == 8'h02));

  p_order_a_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && frame_rdy_i && cmd_addr_o == 8'h02) |=> (cmd_addr_o == 8'h04));

  p_order_b_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && frame_rdy_i && cmd_addr_o == 8'h04) |=> (cmd_addr_o == 8'h18));

  p_order_c_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && frame_rdy_i && cmd_addr_o == 8'h18) |=> (cmd_addr_o == 8'h1A));

  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && frame_rdy_i && cmd_addr_o == 8'h1A) |=> (cmd_addr_o == 8'h02));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && !frame_rdy_i) |=> ($stable(cmd_addr_o) && $stable(cmd_data_o)));

  p_vol_fmt_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_addr_o != 8'h1A) |->
      (cmd_data_o[15:13] == 3'b0 && cmd_data_o[7:5] == 3'b0 &&
       cmd_data_o[12:8] == cmd_data_o[4:0]));

  p_src_fmt_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && cmd_addr_o == 8'h1A) |->
      (cmd_data_o[15:11] == 5'b0 && cmd_data_o[7:3] == 5'b0 &&
       cmd_data_o[10:8] == cmd_data_o[2:0]));

  p_write_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |-> !cmd_addr_o[7]);

  p_live_vol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && frame_rdy_i && cmd_addr_o != 8'h18) |=>
      (cmd_data_o[4:0] == $past(vol_i)));

  p_live_src_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld_o && frame_rdy_i && cmd_addr_o == 8'h18) |=>
      (cmd_data_o[2:0] == $past(src_sel_i)));

  p_valid_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_vld_o |=> cmd_vld_o);

endmodule

bind codec_cfg_seq codec_cfg_seq_chk u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .codec_ready_i (codec_ready_i),
  .frame_rdy_i   (frame_rdy_i),
  .src_sel_i     (src_sel_i),
  .vol_i         (vol_i),
  .cmd_addr_o    (cmd_addr_o),
  .cmd_data_o    (cmd_data_o),
  .cmd_vld_o     (cmd_vld_o)
);

// File: tb/codec_cfg_seq_tb.sv
module codec_cfg_seq_tb;

  localparam time CLK_PERIOD = 10ns;

  logic        clk;
  logic        rst_n;
  logic        codec_ready_i;
  logic        frame_rdy_i;
  logic [2:0]  src_sel_i;
  logic [4:0]  vol_i;
  logic [7:0]  cmd_addr_o;
  logic [15:0] cmd_data_o;
  logic        cmd_vld_o;

  int n_chk  = 0;
  int n_fail = 0;
  int pos    = 0;
  bit done   = 0;

  codec_cfg_seq u_dut (
    .clk           (clk),
    .rst_n         (rst_n),
    .codec_ready_i (codec_ready_i),
    .frame_rdy_i   (frame_rdy_i),
    .src_sel_i     (src_sel_i),
    .vol_i         (vol_i),
    .cmd_addr_o    (cmd_addr_o),
    .cmd_data_o    (cmd_data_o),
    .cmd_vld_o     (cmd_vld_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] exp_addr(input int p);
    case (p % 4)
      0: exp_addr = 8'h02;
      1: exp_addr = 8'h04;
      2: exp_addr = 8'h18;
      default: exp_addr = 8'h1A;
    endcase
  endfunction

  function automatic logic [15:0] exp_data(input int p, input int v, input int s);
    if (p % 4 == 3) exp_data = 16'((s << 8) | s);
    else            exp_data = 16'((v << 8) | v);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input int v, input int s);
    @(negedge clk);
    vol_i       = 5'(v);
    src_sel_i   = 3'(s);
    frame_rdy_i = 1'b1;
    @(negedge clk);
    frame_rdy_i = 1'b0;
    pos = (pos + 1) % 4;
  endtask

  initial begin
    rst_n = 1'b0; codec_ready_i = 1'b0; frame_rdy_i = 1'b0;
    vol_i = '0; src_sel_i = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 vld", 32'(cmd_vld_o), 0);
    check("R1 addr", 32'(cmd_addr_o), 0);
    check("R1 data", 32'(cmd_data_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 vld after release", 32'(cmd_vld_o), 0);

    // R2: pulses before codec ready are ignored
    for (int i = 0; i < 3; i++) begin
      pulse(7, 5);
      check("R2 idle vld", 32'(cmd_vld_o), 0);
      check("R2 idle data", 32'(cmd_data_o), 0);
    end
    pos = 0;

    // R2/R8: codec ready loads the first entry with live inputs
    @(negedge clk);
    vol_i = 5'd19; src_sel_i = 3'd6; codec_ready_i = 1'b1;
    @(negedge clk);
    check("R2 first vld", 32'(cmd_vld_o), 1);
    check("R2 first addr", 32'(cmd_addr_o), 32'(exp_addr(0)));
    check("R8 first data", 32'(cmd_data_o), 32'(exp_data(0, 19, 6)));

    // R10: dropping codec ready later has no effect
    codec_ready_i = 1'b0;
    repeat (3) @(negedge clk);
    check("R10 vld kept", 32'(cmd_vld_o), 1);
    check("R10 addr kept", 32'(cmd_addr_o), 32'(exp_addr(0)));

    // R3/R5/R6/R7/R8/R9 sweep over every volume and source code
    for (int v = 0; v < 32; v++) begin
      for (int s = 0; s < 8; s++) begin
        pulse(v, s);
        check("R3 addr", 32'(cmd_addr_o), 32'(exp_addr(pos)));
        check(pos == 3 ? "R6 data" : "R5 data", 32'(cmd_data_o), 32'(exp_data(pos, v, s)));
        check("R7 write bit", 32'(cmd_addr_o[7]), 0);
        check("R9 vld", 32'(cmd_vld_o), 1);
        if ((s % 4) == 1) begin
          // R4: inputs move, no pulse, command held
          vol_i = 5'(~v); src_sel_i = 3'(~s);
          repeat (4) @(negedge clk);
          check("R4 hold addr", 32'(cmd_addr_o), 32'(exp_addr(pos)));
          check("R4 hold data", 32'(cmd_data_o), 32'(exp_data(pos, v, s)));
        end
      end
    end

    // R10: ready low again, still advancing
    pulse(3, 2);
    check("R10 advance", 32'(cmd_addr_o), 32'(exp_addr(pos)));
    check("R8 live data", 32'(cmd_data_o), 32'(exp_data(pos, 3, 2)));
    done = 1;
  end

  initial begin
    for (int c = 0; c < 20000; c++) begin
      @(negedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule